// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit with Flag Register

This block is the arithmetic and logic stage of a small 8-bit processor. Each cycle it may accept one operation. An operation has a 4-bit operation code, the current value of the destination register, and a second operand. The second operand is either a register value or an 8-bit immediate, selected by `use_imm`. One clock edge after an accepted operation, the block presents the value to write back into the destination register and raises `wb_valid` for that cycle. It also updates a four-bit flag register that holds zero, carry, negative and overflow.

The operations are addition and subtraction, each with and without the carry flag as an extra input. The logic operations are NAND and XOR. Logical shifts move the destination left or right by a variable amount taken from the second operand. A move passes the second operand through unchanged. Operation codes 1001 through 1111 belong to other units of the processor. This block ignores them. Register storage, memory, stack and control flow are handled outside the block.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `wb_valid` is 0 and `flags` is 0. These values hold until the first accepted operation after reset is released. Reset release takes effect through a two-stage synchronizer.
- R2: With `en` high, code 0000 produces destination + operand and code 0001 produces destination − operand, both modulo 256. The result appears on `result` with `wb_valid` high one clock edge later. For addition, carry (`flags[1]`) is the unsigned carry out. For subtraction, carry is a borrow and is set when the unsigned result underflows.
- R3: Code 0010 produces destination + operand + carry. Code 0011 produces destination − operand − carry. Both use the carry flag held before the operation, and both set the carry flag as R2 describes.
- R4: On codes 0000–0011, overflow (`flags[3]`) is set when the signed result falls outside −128..127. This is equivalent to two same-signed adder inputs giving a result of the opposite sign.
- R5: Code 0100 produces the bitwise NAND of destination and operand. Code 0101 produces their bitwise XOR.
- R6: Code 0110 shifts the destination left and code 0111 shifts it right by the unsigned value of the operand. Vacated bits fill with zeros, and an amount of 8 or more gives 0.
- R7: After a shift, carry holds the last bit shifted out. That bit is 0 for an amount of 0 or of 9 and more. After a shift, overflow is 0.
- R8: Code 1000 passes the operand through unchanged. The operand is `imm_val` when `use_imm` is 1 and `reg_val` otherwise. This selection applies to every code.
- R9: On every accepted code 0000–1000, zero (`flags[0]`) is set when the result is 0. On the same codes, negative (`flags[2]`) becomes bit 7 of the result.
- R10: Codes 0100, 0101 and 1000 leave carry and overflow unchanged.
- R11: With `en` high and a code of 1001–1111, `wb_valid` is 0 on the next cycle, and `result` and `flags` keep their values.
- R12: With `en` low, `wb_valid` is 0 on the next cycle, and `result` and `flags` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| dst_val | input | 8 | Current destination register value |
| reg_val | input | 8 | Second operand from a register |
| imm_val | input | 8 | Second operand as an immediate |
| use_imm | input | 1 | 1 selects `imm_val`, 0 selects `reg_val` |
| result | output | 8 | Write-back value |
| wb_valid | output | 1 | `result` is to be written this cycle |
| flags | output | 4 | {overflow, negative, carry, zero} |

## Verification
The checker watches the register-level rules on every cycle. These rules are: zero and negative track the presented result; carry and overflow hold across logic and move operations; foreign codes and idle cycles change nothing; shifts by 8 or more clear the result; move and NAND results match the sampled operands. The arithmetic values themselves, the carry and borrow chains between consecutive add-with-carry and subtract-with-borrow operations, and the overflow boundary cases are shown only by the bench. The bench applies directed and pseudo-random sequences and compares them against an integer reference model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OPW = 4;

  localparam logic [OPW-1:0] OP_ADD  = 4'h0;
  localparam logic [OPW-1:0] OP_SUB  = 4'h1;
  localparam logic [OPW-1:0] OP_ADC  = 4'h2;
  localparam logic [OPW-1:0] OP_SBB  = 4'h3;
  localparam logic [OPW-1:0] OP_NAND = 4'h4;
  localparam logic [OPW-1:0] OP_XOR  = 4'h5;
  localparam logic [OPW-1:0] OP_SHL  = 4'h6;
  localparam logic [OPW-1:0] OP_SHR  = 4'h7;
  localparam logic [OPW-1:0] OP_MOV  = 4'h8;

  localparam int unsigned FLG_Z = 0;
  localparam int unsigned FLG_C = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLGW  = 4;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic         c_out;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    {c_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    // subtract: a carry out of the adder means no borrow
    carry = sub ? ~c_out : c_out;
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned W    = 8,
  parameter bit          LEFT = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] amt,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W:0] ext;

  generate
    if (LEFT) begin : g_left
      // spare top bit catches the last bit shifted out
      always_comb begin
        ext  = {1'b0, a} << amt;
        res  = ext[W-1:0];
        cout = ext[W];
      end
    end else begin : g_right
      // spare bottom bit catches the last bit shifted out
      always_comb begin
        ext  = {a, 1'b0} >> amt;
        res  = ext[W:1];
        cout = ext[0];
      end
    end
  endgenerate
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [OPW-1:0]  op,
  input  logic [W-1:0]    dst_val,
  input  logic [W-1:0]    reg_val,
  input  logic [W-1:0]    imm_val,
  input  logic            use_imm,
  output logic [W-1:0]    result,
  output logic            wb_valid,
  output logic [FLGW-1:0] flags
);
  logic [1:0]   rst_pipe;
  logic         rst_sync_n;

  logic [W-1:0] opnd_b;
  logic [W-1:0] as_sum, shl_res, shr_res;
  logic         as_c, as_v, shl_c, shr_c;

  logic         alu_en, cv_en;
  logic [W-1:0] res_d;
  logic         cf_d, vf_d;

  logic [W-1:0] res_q;
  logic         vld_q;
  logic         zf_q, cf_q, nf_q, vf_q;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign opnd_b = use_imm ? imm_val : reg_val;

  alu8_addsub #(.W(W)) u_addsub (
    .a     (dst_val),
    .b     (opnd_b),
    .cin   (op[1] & cf_q),
    .sub   (op[0]),
    .sum   (as_sum),
    .carry (as_c),
    .ovf   (as_v)
  );

  alu8_shift #(.W(W), .LEFT(1'b1)) u_shl (
    .a (dst_val), .amt (opnd_b), .res (shl_res), .cout (shl_c)
  );

  alu8_shift #(.W(W), .LEFT(1'b0)) u_shr (
    .a (dst_val), .amt (opnd_b), .res (shr_res), .cout (shr_c)
  );

  // next-state selection
  always_comb begin
    alu_en = en && (op <= OP_MOV);
    cv_en  = 1'b0;
    res_d  = opnd_b;
    cf_d   = cf_q;
    vf_d   = vf_q;
    case (op)
      OP_ADD, OP_SUB, OP_ADC, OP_SBB: begin
        res_d = as_sum;
        cf_d  = as_c;
        vf_d  = as_v;
        cv_en = 1'b1;
      end
      OP_NAND: res_d = ~(dst_val & opnd_b);
      OP_XOR:  res_d = dst_val ^ opnd_b;
      OP_SHL: begin
        res_d = shl_res;
        cf_d  = shl_c;
        vf_d  = 1'b0;
        cv_en = 1'b1;
      end
      OP_SHR: begin
        res_d = shr_res;
        cf_d  = shr_c;
        vf_d  = 1'b0;
        cv_en = 1'b1;
      end
      default: res_d = opnd_b;
    endcase
  end

  // result and write-back strobe
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= alu_en;
      if (alu_en) res_q <= res_d;
    end
  end

  // zero / negative: every accepted operation
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      zf_q <= 1'b0;
      nf_q <= 1'b0;
    end else if (alu_en) begin
      zf_q <= (res_d == '0);
      nf_q <= res_d[W-1];
    end
  end

  // carry / overflow: arithmetic and shifts only
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cf_q <= 1'b0;
      vf_q <= 1'b0;
    end else if (alu_en && cv_en) begin
      cf_q <= cf_d;
      vf_q <= vf_d;
    end
  end

  assign result   = res_q;
  assign wb_valid = vld_q;
  always_comb begin
    flags        = '0;
    flags[FLG_Z] = zf_q;
    flags[FLG_C] = cf_q;
    flags[FLG_N] = nf_q;
    flags[FLG_V] = vf_q;
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [OPW-1:0]  op,
  input logic [W-1:0]    dst_val,
  input logic [W-1:0]    reg_val,
  input logic [W-1:0]    imm_val,
  input logic            use_imm,
  input logic [W-1:0]    result,
  input logic            wb_valid,
  input logic [FLGW-1:0] flags
);
  logic [W-1:0] b_sel;
  assign b_sel = use_imm ? imm_val : reg_val;

  // R9: zero and negative follow the presented result
  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (flags[FLG_Z] == (result == '0)));
  a_r9_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (flags[FLG_N] == result[W-1]));

  // R10: logic and move keep carry and overflow
  a_r10_cv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_NAND || op == OP_XOR || op == OP_MOV))
      |=> ($stable(flags[FLG_C]) && $stable(flags[FLG_V])));

  // R11: foreign codes write nothing
  a_r11_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op > OP_MOV) |=> (!wb_valid && $stable(flags) && $stable(result)));

  // R12: idle cycles write nothing
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!wb_valid && $stable(flags) && $stable(result)));

  // R6, R7: large shift amounts clear the result, overflow cleared
  a_r6_wide_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_SHL || op == OP_SHR) && b_sel >= W[W-1:0])
      |=> (wb_valid && result == '0 && !flags[FLG_V]));

  // R8: move passes the selected operand
  a_r8_move: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_MOV) |=> (wb_valid && result == $past(b_sel)));

  // R5: NAND of the sampled operands
  a_r5_nand: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_NAND) |=> (result == ~($past(dst_val) & $past(b_sel))));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .op       (op),
  .dst_val  (dst_val),
  .reg_val  (reg_val),
  .imm_val  (imm_val),
  .use_imm  (use_imm),
  .result   (result),
  .wb_valid (wb_valid),
  .flags    (flags)
);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] op;
  logic [7:0] dst_val, reg_val, imm_val;
  logic       use_imm;
  logic [7:0] result;
  logic       wb_valid;
  logic [3:0] flags;

  int vec_cnt  = 0;
  int fail_cnt = 0;

  // reference state: {V,N,C,Z} at bits 3..0
  int exp_res = 0;
  int exp_vld = 0;
  int ez = 0, ec = 0, en_f = 0, ev = 0;
  string last_tag = "R1";

  always #4 clk = ~clk;   // 125 MHz

  alu8_core dut_i (
    .clk (clk), .rst_n (rst_n), .en (en), .op (op),
    .dst_val (dst_val), .reg_val (reg_val), .imm_val (imm_val),
    .use_imm (use_imm), .result (result), .wb_valid (wb_valid),
    .flags (flags)
  );

  function automatic string tag_of(input logic e, input int o);
    if (!e)      return "R12";
    if (o > 8)   return "R11";
    if (o <= 1)  return "R2 R4 R9";
    if (o <= 3)  return "R3 R4 R9";
    if (o <= 5)  return "R5 R9 R10";
    if (o <= 7)  return "R6 R7 R9";
    return "R8 R9 R10";
  endfunction

  task automatic compare(input string tag);
    int got_f, exp_f;
    vec_cnt++;
    got_f = int'(flags);
    exp_f = ev * 8 + en_f * 4 + ec * 2 + ez;
    if (int'(result) != exp_res || int'(wb_valid) != exp_vld || got_f != exp_f) begin
      fail_cnt++;
      $display("FAIL %s: result=%0h valid=%0d flags=%0h expected result=%0h valid=%0d flags=%0h",
               tag, result, wb_valid, flags, exp_res, exp_vld, exp_f);
    end
  endtask

  // Reference model: update expected state for one applied cycle.
  task automatic model(input logic e, input int o, input int a, input int b);
    int r, s, amt;
    exp_vld = 0;
    if (!e || o > 8) return;
    exp_vld = 1;
    amt = b;
    case (o)
      0, 2: begin
        s  = a + b + ((o == 2) ? ec : 0);
        r  = s % 256;
        ec = (s > 255) ? 1 : 0;
        s  = (a > 127 ? a - 256 : a) + (b > 127 ? b - 256 : b) + ((o == 2) ? (s - a - b) : 0);
        ev = (s > 127 || s < -128) ? 1 : 0;
      end
      1, 3: begin
        s  = a - b - ((o == 3) ? ec : 0);
        r  = (s + 512) % 256;
        s  = (a > 127 ? a - 256 : a) - (b > 127 ? b - 256 : b) - ((o == 3) ? ec : 0);
        ec = (a - b - ((o == 3) ? ec : 0)) < 0 ? 1 : 0;
        ev = (s > 127 || s < -128) ? 1 : 0;
      end
      4: r = 255 - (a & b);
      5: r = a ^ b;
      6: begin
        if (amt == 0)      begin r = a; ec = 0; end
        else if (amt <= 8) begin r = (a << amt) % 256; ec = (a >> (8 - amt)) & 1; end
        else               begin r = 0; ec = 0; end
        ev = 0;
      end
      7: begin
        if (amt == 0)      begin r = a; ec = 0; end
        else if (amt <= 8) begin r = a >> amt; ec = (a >> (amt - 1)) & 1; end
        else               begin r = 0; ec = 0; end
        ev = 0;
      end
      default: r = b;
    endcase
    exp_res = r;
    ez   = (r == 0) ? 1 : 0;
    en_f = (r >= 128) ? 1 : 0;
  endtask

  // Called at a falling edge; compares at the next falling edge.
  task automatic apply(input logic e, input int o, input int a, input int b, input logic ui);
    int other;
    other   = (b * 37 + 11) % 256;   // the unselected source carries noise
    en      = e;
    op      = 4'(o);
    dst_val = 8'(a);
    use_imm = ui;
    imm_val = ui ? 8'(b) : 8'(other);
    reg_val = ui ? 8'(other) : 8'(b);
    last_tag = tag_of(e, o);
    model(e, o, a, b);
    @(negedge clk);
    compare(last_tag);
  endtask

  // watchdog: counts as a failed check
  initial begin
    #(8 * 150000);
    fail_cnt++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op = '0; dst_val = '0;
    reg_val = '0; imm_val = '0; use_imm = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");

    // R2 R4: signed overflow on add, carry and zero on wrap
    apply(1, 0, 8'h7F, 8'h01, 1);
    apply(1, 0, 8'hFF, 8'h01, 0);
    // R2: borrow on underflow, overflow on subtract
    apply(1, 1, 8'h00, 8'h01, 1);
    apply(1, 1, 8'h80, 8'h01, 0);
    apply(1, 1, 8'h05, 8'h05, 1);
    // R3: carry chain then borrow chain
    apply(1, 0, 8'hF0, 8'h20, 1);
    apply(1, 2, 8'h01, 8'h01, 1);
    apply(1, 1, 8'h10, 8'h20, 0);
    apply(1, 3, 8'h10, 8'h0F, 0);
    apply(1, 3, 8'h00, 8'h7F, 1);
    // R5 R10: logic keeps C and V from before
    apply(1, 0, 8'h7F, 8'h7F, 1);
    apply(1, 4, 8'hFF, 8'hFF, 0);
    apply(1, 5, 8'hA5, 8'h5A, 1);
    // R6 R7: shift amounts 0, 1, 7, 8, 9, 255
    apply(1, 6, 8'h81, 8'd0, 1);
    apply(1, 6, 8'h81, 8'd1, 1);
    apply(1, 6, 8'h81, 8'd7, 0);
    apply(1, 6, 8'h01, 8'd8, 1);
    apply(1, 6, 8'hFF, 8'd9, 1);
    apply(1, 7, 8'h81, 8'd1, 1);
    apply(1, 7, 8'h80, 8'd8, 0);
    apply(1, 7, 8'hFF, 8'd255, 1);
    // R8 R9: move from immediate and from register
    apply(1, 8, 8'h00, 8'h9C, 1);
    apply(1, 8, 8'hFF, 8'h00, 0);
    // R11 R12: foreign codes and idle cycles leave everything
    apply(1, 9, 8'h12, 8'h34, 1);
    apply(1, 15, 8'h00, 8'h00, 0);
    apply(0, 0, 8'hFF, 8'hFF, 1);
    apply(0, 6, 8'h00, 8'h00, 0);

    for (int i = 0; i < 1500; i++) begin
      int o, a, b;
      logic e;
      e = ($urandom % 8) != 0;
      o = $urandom % 16;
      a = $urandom % 256;
      b = (o >= 6 && o <= 7) ? ($urandom % 12) : ($urandom % 256);
      apply(e, o, a, b, 1'($urandom % 2));
    end

    en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end
endmodule